// File: doc/BRIEF.md
# Single-Channel PWM Generator with Input Capture

This block is one pulse-width channel controlled through a small word-addressed register interface. A two-stage divider turns the bus clock into a counting tick, and a 32-bit counter advances on that tick. The counter produces one of three things: a pulse train with programmable period and high time, a measurement of how long an input signal stays high and how long it stays low, or nothing at all while the output is held at a constant reference level.

Waveform output runs either continuously or for a set number of periods, after which the channel switches itself off. Period and high-time writes are staged and take effect only where one period ends and the next begins, so a running waveform never shows a truncated or stretched pulse. Period ends, the end of a one-shot run and capture events set a pending flag, and the interrupt line reflects that flag when interrupts are enabled.

Top module: `pwm_channel`

## Requirements
- R1: After reset every register reads zero and both `pwm_out` and `irq` are low.
- R2: The control word at address 0 holds enable in bit 0, mode in bits 2:1 (0 continuous, 1 one-shot, 2 capture, 3 reference), reference level in bit 3, interrupt enable in bit 4, prescale PS in bits 15:8 and scale SC in bits 23:16. One counting tick occurs every (PS+1)*(SC+1) clock cycles, so a running waveform repeats every PERIOD ticks, where PERIOD is at address 1 and a value of 0 acts as 1.
- R3: In continuous mode `pwm_out` is high for the first min(DUTY, PERIOD) ticks of each period and low for the remainder, with DUTY at address 2. It lags the counter by one register stage. DUTY 0 gives a constant low, and DUTY at or above PERIOD gives a constant high.
- R4: Writes to PERIOD or DUTY while the waveform is running do not alter the period in progress and apply from the next period boundary onward.
- R5: In one-shot mode the channel outputs REPEAT periods, with REPEAT at address 3 and 0 acting as 1. It then clears the enable bit itself and drives `pwm_out` low.
- R6: In reference mode `pwm_out` follows control bit 3 while the channel is enabled, and no interrupt event is raised.
- R7: In capture mode `cap_in` passes through two synchroniser stages. At every change of level, the number of ticks the previous level lasted is stored: high durations go to address 4, low durations go to address 5, and status bit 1 (address 6) is set to 1 after a high measurement and to 0 after a low one.
- R8: Status bit 0 is set by each continuous period end, by one-shot completion and by each capture. Writing 1 to it clears it, and writing 0 leaves it unchanged. `irq` equals that bit ANDed with the interrupt enable.
- R9: With enable clear, `pwm_out` is low and no period events occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| cap_in | input | 1 | Asynchronous signal to measure in capture mode |
| pwm_out | output | 1 | Registered waveform or reference output |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench sweeps prescale, scale, period and high-time values through the degenerate cases: a one-tick period, a zero high time, and a high time longer than the period. A divider that is off by one, or a compare that uses the wrong bound, would change the high-cycle count over a window of exactly two periods. A high-time write lands in the middle of a running period; if the value were not staged, that period would come out with the new pulse width instead of the old one. One-shot runs with a repeat count of 0, 1 and 3 would expose a repeat counter that stops early or late, or an enable bit that never clears. Capture pulses as short as one cycle would expose an edge detector that drops narrow pulses, or a count that is one tick short because it ignores the tick in the edge cycle.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    MODE_CONT    = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_REF     = 2'd3
  } pwm_mode_e;

  // register word addresses
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_PERIOD = 1;
  localparam int unsigned REG_DUTY   = 2;
  localparam int unsigned REG_REPEAT = 3;
  localparam int unsigned REG_CAPHI  = 4;
  localparam int unsigned REG_CAPLO  = 5;
  localparam int unsigned REG_STATUS = 6;

  // control word field positions
  localparam int unsigned CTRL_EN      = 0;
  localparam int unsigned CTRL_MODE_LO = 1;
  localparam int unsigned CTRL_REF     = 3;
  localparam int unsigned CTRL_IEN     = 4;
  localparam int unsigned CTRL_PRE_LO  = 8;
  localparam int unsigned CTRL_SCL_LO  = 16;

  // status word field positions
  localparam int unsigned STS_PEND = 0;
  localparam int unsigned STS_POL  = 1;

endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic [SCL_W-1:0] scl_lim,
  output logic             tick
);
  localparam logic [PRE_W-1:0] PRE_ONE = 1;
  localparam logic [SCL_W-1:0] SCL_ONE = 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SCL_W-1:0] scl_q, scl_d;
  logic             pre_wrap;

  always_comb begin
    pre_wrap = run && (pre_q == pre_lim);
    tick     = pre_wrap && (scl_q == scl_lim);
    pre_d    = pre_q;
    scl_d    = scl_q;
    if (!run) begin
      pre_d = '0;
      scl_d = '0;
    end else begin
      pre_d = pre_wrap ? '0 : pre_q + PRE_ONE;
      if (pre_wrap) scl_d = tick ? '0 : scl_q + SCL_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      scl_q <= '0;
    end else begin
      pre_q <= pre_d;
      scl_q <= scl_d;
    end
  end
endmodule

// File: rtl/pwm_edge_sync.sv
`timescale 1ns/1ps
module pwm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic chg,
  output logic prev_lvl
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its delayed copy
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d     = {sh_q[STAGES-1:0], din};
    chg      = sh_q[STAGES-1] ^ sh_q[STAGES];
    prev_lvl = sh_q[STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/pwm_core.sv
`timescale 1ns/1ps
module pwm_core
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  pwm_mode_e        mode,
  input  logic             ref_lvl,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] repeat_n,
  input  logic             tick,
  input  logic             chg,
  output logic             wave_out,
  output logic             ev_period,
  output logic             ev_done,
  output logic             ev_cap,
  output logic [CNT_W-1:0] cap_val
);
  localparam logic [CNT_W-1:0] ONE   = 1;
  localparam logic [CNT_W:0]   ONE_X = 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rep_q, rep_d;
  logic [CNT_W-1:0] per_sh_q, per_sh_d;
  logic [CNT_W-1:0] duty_sh_q, duty_sh_d;
  logic             out_q, out_d;
  logic             wave_run, cap_run, per_end, last_rep;

  always_comb begin
    wave_run  = en && (mode == MODE_CONT || mode == MODE_ONESHOT);
    cap_run   = en && (mode == MODE_CAPTURE);
    per_end   = wave_run && tick && (({1'b0, cnt_q} + ONE_X) >= {1'b0, per_sh_q});
    last_rep  = ({1'b0, rep_q} + ONE_X) >= {1'b0, repeat_n};
    ev_period = per_end && (mode == MODE_CONT);
    ev_done   = per_end && (mode == MODE_ONESHOT) && last_rep;
    ev_cap    = cap_run && chg;
    cap_val   = tick ? cnt_q + ONE : cnt_q;

    cnt_d = cnt_q;
    if (!(wave_run || cap_run)) cnt_d = '0;
    else if (per_end || ev_cap) cnt_d = '0;
    else if (tick)              cnt_d = cnt_q + ONE;

    rep_d = rep_q;
    if (!wave_run)    rep_d = '0;
    else if (per_end) rep_d = rep_q + ONE;

    per_sh_d  = per_sh_q;
    duty_sh_d = duty_sh_q;
    if (!wave_run || per_end) begin
      per_sh_d  = period;
      duty_sh_d = duty;
    end

    if (wave_run)                          out_d = (cnt_q < duty_sh_q);
    else if (en && (mode == MODE_REF))     out_d = ref_lvl;
    else                                   out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rep_q     <= '0;
      per_sh_q  <= '0;
      duty_sh_q <= '0;
      out_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rep_q     <= rep_d;
      per_sh_q  <= per_sh_d;
      duty_sh_q <= duty_sh_d;
      out_q     <= out_d;
    end
  end

  assign wave_out = out_q;
endmodule

// File: rtl/pwm_chan_regs.sv
`timescale 1ns/1ps
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SCL_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              ev_period,
  input  logic              ev_done,
  input  logic              ev_cap,
  input  logic [CNT_W-1:0]  cap_val,
  input  logic              cap_high,
  output logic              en,
  output pwm_mode_e         mode,
  output logic              ref_lvl,
  output logic [PRE_W-1:0]  pre_lim,
  output logic [SCL_W-1:0]  scl_lim,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  duty,
  output logic [CNT_W-1:0]  repeat_n,
  output logic              pend,
  output logic              irq
);
  logic             en_q, en_d, ref_q, ref_d, ien_q, ien_d, pend_q, pend_d, pol_q, pol_d;
  pwm_mode_e        mode_q, mode_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SCL_W-1:0] scl_q, scl_d;
  logic [CNT_W-1:0] per_q, per_d, duty_q, duty_d, rep_q, rep_d;
  logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             wr_ctrl, wr_per, wr_duty, wr_rep, wr_sts;

  always_comb begin
    wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
    wr_per  = wr_en && (addr == ADDR_W'(REG_PERIOD));
    wr_duty = wr_en && (addr == ADDR_W'(REG_DUTY));
    wr_rep  = wr_en && (addr == ADDR_W'(REG_REPEAT));
    wr_sts  = wr_en && (addr == ADDR_W'(REG_STATUS));

    en_d = en_q; mode_d = mode_q; ref_d = ref_q; ien_d = ien_q;
    pre_d = pre_q; scl_d = scl_q;
    if (wr_ctrl) begin
      en_d   = wdata[CTRL_EN];
      mode_d = pwm_mode_e'(wdata[CTRL_MODE_LO +: 2]);
      ref_d  = wdata[CTRL_REF];
      ien_d  = wdata[CTRL_IEN];
      pre_d  = wdata[CTRL_PRE_LO +: PRE_W];
      scl_d  = wdata[CTRL_SCL_LO +: SCL_W];
    end else if (ev_done) begin
      en_d = 1'b0;
    end

    per_d  = wr_per  ? wdata : per_q;
    duty_d = wr_duty ? wdata : duty_q;
    rep_d  = wr_rep  ? wdata : rep_q;

    hi_d  = (ev_cap && cap_high)  ? cap_val : hi_q;
    lo_d  = (ev_cap && !cap_high) ? cap_val : lo_q;
    pol_d = ev_cap ? cap_high : pol_q;

    pend_d = (pend_q && !(wr_sts && wdata[STS_PEND])) || ev_period || ev_done || ev_cap;

    rdata = '0;
    case (addr)
      ADDR_W'(REG_CTRL): begin
        rdata[CTRL_EN]              = en_q;
        rdata[CTRL_MODE_LO +: 2]    = mode_q;
        rdata[CTRL_REF]             = ref_q;
        rdata[CTRL_IEN]             = ien_q;
        rdata[CTRL_PRE_LO +: PRE_W] = pre_q;
        rdata[CTRL_SCL_LO +: SCL_W] = scl_q;
      end
      ADDR_W'(REG_PERIOD): rdata = per_q;
      ADDR_W'(REG_DUTY):   rdata = duty_q;
      ADDR_W'(REG_REPEAT): rdata = rep_q;
      ADDR_W'(REG_CAPHI):  rdata = hi_q;
      ADDR_W'(REG_CAPLO):  rdata = lo_q;
      ADDR_W'(REG_STATUS): begin
        rdata[STS_PEND] = pend_q;
        rdata[STS_POL]  = pol_q;
      end
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= MODE_CONT; ref_q <= 1'b0; ien_q <= 1'b0;
      pre_q <= '0; scl_q <= '0;
      per_q <= '0; duty_q <= '0; rep_q <= '0;
      hi_q <= '0; lo_q <= '0; pol_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      en_q <= en_d; mode_q <= mode_d; ref_q <= ref_d; ien_q <= ien_d;
      pre_q <= pre_d; scl_q <= scl_d;
      per_q <= per_d; duty_q <= duty_d; rep_q <= rep_d;
      hi_q <= hi_d; lo_q <= lo_d; pol_q <= pol_d; pend_q <= pend_d;
    end
  end

  assign en       = en_q;
  assign mode     = mode_q;
  assign ref_lvl  = ref_q;
  assign pre_lim  = pre_q;
  assign scl_lim  = scl_q;
  assign period   = per_q;
  assign duty     = duty_q;
  assign repeat_n = rep_q;
  assign pend     = pend_q;
  assign irq      = pend_q & ien_q;
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SCL_W       = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  logic             ctl_en, ctl_ref, pend, tick, cnt_run;
  pwm_mode_e        ctl_mode;
  logic [PRE_W-1:0] ctl_pre;
  logic [SCL_W-1:0] ctl_scl;
  logic [CNT_W-1:0] cfg_period, cfg_duty, cfg_repeat, cap_val;
  logic             cap_chg, cap_prev;
  logic             ev_period, ev_done, ev_cap;

  assign cnt_run = ctl_en && (ctl_mode != MODE_REF);

  pwm_chan_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SCL_W(SCL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ev_period(ev_period), .ev_done(ev_done), .ev_cap(ev_cap),
    .cap_val(cap_val), .cap_high(cap_prev), .en(ctl_en), .mode(ctl_mode),
    .ref_lvl(ctl_ref), .pre_lim(ctl_pre), .scl_lim(ctl_scl), .period(cfg_period),
    .duty(cfg_duty), .repeat_n(cfg_repeat), .pend(pend), .irq(irq)
  );

  pwm_prescale #(.PRE_W(PRE_W), .SCL_W(SCL_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .run(cnt_run), .pre_lim(ctl_pre), .scl_lim(ctl_scl),
    .tick(tick)
  );

  pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .chg(cap_chg), .prev_lvl(cap_prev)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .mode(ctl_mode), .ref_lvl(ctl_ref),
    .period(cfg_period), .duty(cfg_duty), .repeat_n(cfg_repeat), .tick(tick),
    .chg(cap_chg), .wave_out(pwm_out), .ev_period(ev_period), .ev_done(ev_done),
    .ev_cap(ev_cap), .cap_val(cap_val)
  );
endmodule

// File: rtl/pwm_channel_chk.sv
`timescale 1ns/1ps
module pwm_channel_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ctl_en,
  input logic [1:0]        ctl_mode,
  input logic              ctl_ref,
  input logic              pwm_out,
  input logic              ev_period,
  input logic              ev_done,
  input logic              ev_cap,
  input logic              pend
);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !pwm_out);

  p_ref_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ctl_mode == 2'd3) |=> (pwm_out == $past(ctl_ref)));

  p_ref_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ctl_mode == 2'd3) |-> !(ev_period || ev_done || ev_cap));

  p_oneshot_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !(reg_wr && reg_addr == ADDR_W'(0))) |=> !ctl_en);

  p_event_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_period || ev_done || ev_cap) |=> pend);

  p_pend_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ev_period || ev_done || ev_cap));
endmodule

bind pwm_channel pwm_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ctl_en(ctl_en), .ctl_mode(ctl_mode), .ctl_ref(ctl_ref), .pwm_out(pwm_out),
  .ev_period(ev_period), .ev_done(ev_done), .ev_cap(ev_cap), .pend(pend)
);

// File: tb/pwm_channel_bench.sv
`timescale 1ns/1ps
module pwm_channel_bench;
  localparam int A_CTRL = 0, A_PER = 1, A_DUTY = 2, A_REP = 3;
  localparam int A_HI = 4, A_LO = 5, A_STS = 6;
  localparam int M_CONT = 0, M_ONE = 1, M_CAP = 2, M_REF = 3;

  logic        clk, rst_n, reg_wr, cap_in;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        pwm_out, irq;

  int n_chk, n_fail;
  int hi, len, rises, p, d, dv, rep, h, l;
  logic prev;
  logic [31:0] rv;

  pwm_channel u_pwm_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(v);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = 3'(a);
    #0.5;
    v = reg_rdata;
  endtask

  function automatic int cw(int en, int mode, int rf, int ien, int pre, int scl);
    return en | (mode << 1) | (rf << 3) | (ien << 4) | (pre << 8) | (scl << 16);
  endfunction

  // starts at a sampled rise; counts high cycles and length up to next rise
  task automatic measure(input bit inject, output int hh, output int ll);
    logic pv;
    hh = 1; ll = 1; pv = 1'b1;
    forever begin
      @(negedge clk);
      if (pwm_out && !pv) break;
      hh += int'(pwm_out); ll++; pv = pwm_out;
      if (inject && ll == 3) begin
        reg_wr = 1'b1; reg_addr = 3'(A_DUTY); reg_wdata = 32'd6;
      end else reg_wr = 1'b0;
    end
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a, rv);
      check("R1 register reads zero", rv, 0);
    end
    check("R1 pwm_out low", pwm_out, 0);
    check("R1 irq low", irq, 0);

    // R2 / R3 continuous sweep
    for (int pre = 0; pre < 3; pre++)
      for (int scl = 0; scl < 2; scl++)
        for (int pi = 0; pi < 3; pi++)
          for (int di = 0; di < 4; di++) begin
            p  = (pi == 0) ? 1 : (pi == 1) ? 3 : 5;
            d  = (di == 0) ? 0 : (di == 1) ? 2 : (di == 2) ? 5 : 7;
            dv = (pre + 1) * (scl + 1);
            wr(A_CTRL, 0);
            wr(A_PER, p);
            wr(A_DUTY, d);
            wr(A_CTRL, cw(1, M_CONT, 0, 0, pre, scl));
            repeat (p * dv + 4) @(negedge clk);
            hi = 0; rises = 0; prev = pwm_out;
            repeat (2 * p * dv) begin
              @(negedge clk);
              hi += int'(pwm_out);
              if (pwm_out && !prev) rises++;
              prev = pwm_out;
            end
            check("R3 high cycles over two periods", hi, 2 * ((d < p) ? d : p) * dv);
            if (d > 0 && d < p) check("R2 one rise per period", rises, 2);
          end

    // R4 staged duty update
    wr(A_CTRL, 0);
    wr(A_PER, 8);
    wr(A_DUTY, 2);
    wr(A_CTRL, cw(1, M_CONT, 0, 0, 0, 0));
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    measure(1'b1, hi, len);
    check("R4 period in progress keeps old duty", hi, 2);
    check("R4 period length", len, 8);
    measure(1'b0, hi, len);
    check("R4 next period uses new duty", hi, 6);
    check("R2 period length 8 ticks", len, 8);

    // R5 / R8 one-shot
    for (int ri = 0; ri < 3; ri++) begin
      rep = (ri == 0) ? 0 : (ri == 1) ? 1 : 3;
      wr(A_CTRL, 0);
      wr(A_STS, 1);
      wr(A_PER, 4);
      wr(A_DUTY, 3);
      wr(A_REP, rep);
      wr(A_CTRL, cw(1, M_ONE, 0, 1, 1, 0));
      hi = 0;
      repeat (100) begin
        @(negedge clk);
        hi += int'(pwm_out);
      end
      check("R5 one-shot total high cycles", hi, ((rep == 0) ? 1 : rep) * 3 * 2);
      rd(A_CTRL, rv);
      check("R5 enable cleared after run", rv[0], 0);
      check("R5 output low after run", pwm_out, 0);
      rd(A_STS, rv);
      check("R8 pending after one-shot", rv[0], 1);
      check("R8 irq raised", irq, 1);
    end
    wr(A_STS, 0);
    rd(A_STS, rv);
    check("R8 writing 0 keeps pending", rv[0], 1);
    wr(A_STS, 1);
    rd(A_STS, rv);
    check("R8 writing 1 clears pending", rv[0], 0);
    check("R8 irq dropped", irq, 0);

    // R8 gating: pending without enable gives no irq
    wr(A_PER, 2);
    wr(A_DUTY, 1);
    wr(A_CTRL, cw(1, M_CONT, 0, 0, 0, 0));
    repeat (6) @(negedge clk);
    rd(A_STS, rv);
    check("R8 continuous period sets pending", rv[0], 1);
    check("R8 irq gated by enable bit", irq, 0);

    // R9 disabled
    wr(A_CTRL, cw(0, M_CONT, 0, 1, 0, 0));
    wr(A_STS, 1);
    hi = 0;
    repeat (40) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    check("R9 output low while disabled", hi, 0);
    rd(A_STS, rv);
    check("R9 no event while disabled", rv[0], 0);

    // R6 reference mode
    wr(A_CTRL, cw(1, M_REF, 1, 1, 0, 0));
    repeat (2) @(negedge clk);
    hi = 0;
    repeat (20) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    check("R6 reference high level", hi, 20);
    rd(A_STS, rv);
    check("R6 no interrupt event", rv[0], 0);
    wr(A_CTRL, cw(1, M_REF, 0, 1, 0, 0));
    repeat (2) @(negedge clk);
    hi = 0;
    repeat (10) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    check("R6 reference low level", hi, 0);

    // R7 capture sweep
    wr(A_CTRL, 0);
    cap_in = 1'b0;
    wr(A_CTRL, cw(1, M_CAP, 0, 1, 0, 0));
    repeat (10) @(negedge clk);
    wr(A_STS, 1);
    for (int hi_i = 0; hi_i < 4; hi_i++)
      for (int lo_i = 0; lo_i < 3; lo_i++) begin
        h = (hi_i == 0) ? 1 : (hi_i == 1) ? 2 : (hi_i == 2) ? 5 : 9;
        l = (lo_i == 0) ? 6 : (lo_i == 1) ? 7 : 12;
        cap_in = 1'b1;
        repeat (h) @(negedge clk);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(A_HI, rv);
        check("R7 high duration", rv, h);
        rd(A_STS, rv);
        check("R7 polarity after high pulse", rv[1], 1);
        repeat (l - 4) @(negedge clk);
        cap_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_LO, rv);
        check("R7 low duration", rv, l);
        rd(A_STS, rv);
        check("R7 polarity after low gap", rv[1], 0);
        cap_in = 1'b0;
        repeat (12) @(negedge clk);
      end
    rd(A_STS, rv);
    check("R8 capture sets pending", rv[0], 1);
    check("R8 capture irq", irq, 1);

    summary();
    $finish;
  end
endmodule